// File: doc/BRIEF.md
# Paged Effective Address Generator

This block sits between instruction fetch and execute on a 12-bit word-addressed machine. Memory is split into 32 pages of 128 words. For a memory-reference instruction it forms the address of the operand. A page-select bit in the instruction chooses one of two pages for the 7-bit offset: page zero, or the page the instruction itself was fetched from. If the indirect flag is set, the block fetches one pointer word from that direct address and uses it as the final address. Pointer words in a small window of page zero are auto-incremented: the block reads the pointer, adds one modulo 4096, writes it back, and uses the new value.

A launch pulse presents the instruction word and its fetch address. While the sequence runs, the block reports itself busy. It reaches memory through a single-request port with valid/ready handshaking. It finishes with a one-cycle done strobe, and the effective address is valid during that strobe. Opcodes outside the memory-reference group touch no memory; they finish at once with a bypass flag.

Top module: `paged_ea_gen`

## Requirements
- R1: Instruction bits 11:9 are the opcode, bit 8 the indirect flag, bit 7 the page select and bits 6:0 the offset. With bit 8 clear and bit 7 clear, ea_o equals {5'b0, offset} while done_o is high.
- R2: With bit 8 clear and bit 7 set, ea_o equals {pc_i[11:7], offset}, using the fetch address sampled at launch.
- R3: With bit 8 set and the direct address outside the auto-index window, the block performs exactly one read at the direct address and no write. ea_o equals the word read, and that word is never followed as a further pointer.
- R4: With bit 8 set and the direct address in 0x008..0x00F, the block reads the pointer and writes back the pointer plus one, modulo 4096, at the same address. ea_o equals the incremented value.
- R5: The block never issues a write unless the request address lies in 0x008..0x00F. Addresses just outside that window (0x007, 0x010) are left unmodified.
- R6: Opcodes 6 and 7 raise bypass_o together with done_o one cycle after launch, whatever their indirect bit, and make no memory request. bypass_o is low on opcodes 0 to 5.
- R7: done_o is high for exactly one cycle. It rises 1 cycle after launch for direct and bypass cases. For each memory access it adds one cycle plus the number of cycles that mem_ready_i is held low.
- R8: A start_i pulse while busy_o is high is ignored: the running operation finishes with its own result and produces a single done_o.
- R9: After reset, done_o, busy_o, mem_valid_o and mem_we_o are low.
- R10: While mem_valid_o is high and mem_ready_i is low, the request address, write enable and write data stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse, sampled when idle |
| instr_i | input | 12 | Instruction word |
| pc_i | input | 12 | Address the instruction was fetched from |
| mem_addr_o | output | 12 | Memory request address |
| mem_wdata_o | output | 12 | Memory write data |
| mem_we_o | output | 1 | Write enable for the request |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | 12 | Read data, valid when a read is accepted |
| ea_o | output | 12 | Effective address, valid with done_o |
| done_o | output | 1 | One-cycle completion strobe |
| bypass_o | output | 1 | Non-memory-reference opcode, valid with done_o |
| busy_o | output | 1 | Operation in progress |

## Verification
On every cycle, the embedded properties check the following:
- the single-cycle width of the done strobe and that bypass only appears with done;
- that a stalled request holds still, and that no request appears while idle;
- that writes only target the auto-index window;
- that a completed write-back becomes the reported address on the next cycle.

The page arithmetic needs the directed scenarios, as do the single level of indirection, the modulo-4096 wrap of the pointer and the exact window edges. So do the launch-to-done latency under various ready stalls and the dropping of a launch issued mid-operation. Each of these depends on memory contents and on the instruction pattern the bench chooses.

// File: rtl/paged_ea_pkg.sv
package paged_ea_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_DONE  = 2'd3
   } ea_state_t;

   localparam int OPCODE_W = 3;
   localparam int FLAG_W   = 2;
endpackage

// File: rtl/ea_field_split.sv
module ea_field_split
   import paged_ea_pkg::*;
#(
   parameter int WORD_W      = 12,
   parameter int OFS_W       = 7,
   parameter int MRI_LIMIT   = 6,
   parameter bit CUR_PAGE_EN = 1'b1
) (
   input  logic [WORD_W-1:0] instr,
   input  logic [WORD_W-1:0] pc,
   output logic [WORD_W-1:0] direct_addr,
   output logic              indirect,
   output logic              is_mri
);
   localparam int PAGE_W  = WORD_W - OFS_W;
   localparam int IND_BIT = WORD_W - OPCODE_W - 1;
   localparam int PS_BIT  = IND_BIT - 1;

   if (WORD_W != OPCODE_W + FLAG_W + OFS_W) begin : g_fmt_bad
      $error("ea_field_split: instruction fields do not fill the word");
   end
   if (MRI_LIMIT < 1 || MRI_LIMIT > (1 << OPCODE_W)) begin : g_lim_bad
      $error("ea_field_split: MRI_LIMIT out of opcode range");
   end

   logic [OPCODE_W-1:0] opcode;
   logic [OFS_W-1:0]    offset;
   logic [PAGE_W-1:0]   page;

   assign opcode   = instr[WORD_W-1 -: OPCODE_W];
   assign indirect = instr[IND_BIT];
   assign offset   = instr[OFS_W-1:0];
   assign is_mri   = (int'(opcode) < MRI_LIMIT);

   if (CUR_PAGE_EN) begin : g_cur_page
      assign page = instr[PS_BIT] ? pc[WORD_W-1 -: PAGE_W] : '0;
   end else begin : g_zero_only
      logic unused_sel;
      assign unused_sel = instr[PS_BIT] ^ (^pc);
      assign page       = '0;
   end

   assign direct_addr = {page, offset};
endmodule

// File: rtl/ea_autoidx_match.sv
module ea_autoidx_match #(
   parameter int WORD_W     = 12,
   parameter int AUTO_BASE  = 8,
   parameter int AUTO_COUNT = 8,
   parameter bit AUTO_EN    = 1'b1
) (
   input  logic [WORD_W-1:0] addr,
   output logic              hit
);
   if (AUTO_BASE + AUTO_COUNT > (1 << WORD_W)) begin : g_win_bad
      $error("ea_autoidx_match: window exceeds address space");
   end

   if (AUTO_EN && AUTO_COUNT > 0) begin : g_match
      localparam logic [WORD_W:0] LO = (WORD_W+1)'(AUTO_BASE);
      localparam logic [WORD_W:0] HI = (WORD_W+1)'(AUTO_BASE + AUTO_COUNT);
      logic [WORD_W:0] a_ext;
      assign a_ext = {1'b0, addr};
      assign hit   = (a_ext >= LO) && (a_ext < HI);
   end else begin : g_off
      logic unused_addr;
      assign unused_addr = ^addr;
      assign hit         = 1'b0;
   end
endmodule

// File: rtl/ea_seq_fsm.sv
module ea_seq_fsm
   import paged_ea_pkg::*;
#(
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_mri,
   input  logic              indirect,
   input  logic              auto_hit,
   input  logic [WORD_W-1:0] direct_addr,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_valid,
   input  logic              mem_ready,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [WORD_W-1:0] ea,
   output logic              done,
   output logic              bypass,
   output logic              busy
);
   ea_state_t         state_q;
   logic [WORD_W-1:0] ptr_q;
   logic [WORD_W-1:0] ea_q;
   logic [WORD_W-1:0] wdata_q;
   logic              auto_q;
   logic              byp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
         ea_q    <= '0;
         wdata_q <= '0;
         auto_q  <= 1'b0;
         byp_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  ptr_q  <= direct_addr;
                  ea_q   <= direct_addr;
                  auto_q <= auto_hit;
                  byp_q  <= !is_mri;
                  state_q <= (is_mri && indirect) ? ST_READ : ST_DONE;
               end
            end
            ST_READ: begin
               if (mem_ready) begin
                  if (auto_q) begin
                     wdata_q <= mem_rdata + WORD_W'(1);
                     state_q <= ST_WRITE;
                  end else begin
                     ea_q    <= mem_rdata;
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_WRITE: begin
               if (mem_ready) begin
                  ea_q    <= wdata_q;
                  state_q <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign mem_we    = (state_q == ST_WRITE);
   assign mem_addr  = ptr_q;
   assign mem_wdata = wdata_q;
   assign done      = (state_q == ST_DONE);
   assign bypass    = done && byp_q;
   assign busy      = (state_q != ST_IDLE);
   assign ea        = ea_q;

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   bypass_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> (done && !mem_valid));

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=>
         (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R4
   writeback_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_we && mem_ready) |=> (done && ea == $past(mem_wdata)));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_valid && !done));
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen #(
   parameter int WORD_W      = 12,
   parameter int OFS_W       = 7,
   parameter int MRI_LIMIT   = 6,
   parameter int AUTO_BASE   = 8,
   parameter int AUTO_COUNT  = 8,
   parameter bit AUTO_EN     = 1'b1,
   parameter bit CUR_PAGE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] instr_i,
   input  logic [WORD_W-1:0] pc_i,
   output logic [WORD_W-1:0] mem_addr_o,
   output logic [WORD_W-1:0] mem_wdata_o,
   output logic              mem_we_o,
   output logic              mem_valid_o,
   input  logic              mem_ready_i,
   input  logic [WORD_W-1:0] mem_rdata_i,
   output logic [WORD_W-1:0] ea_o,
   output logic              done_o,
   output logic              bypass_o,
   output logic              busy_o
);
   localparam int WIN_HI = AUTO_BASE + AUTO_COUNT;

   if (OFS_W < 1 || OFS_W >= WORD_W) begin : g_ofs_bad
      $error("paged_ea_gen: OFS_W must lie inside the word");
   end
   if (AUTO_EN && (AUTO_BASE + AUTO_COUNT > (1 << OFS_W))) begin : g_win_page
      $error("paged_ea_gen: auto-index window must sit inside page zero");
   end

   logic [WORD_W-1:0] direct_addr;
   logic              indirect;
   logic              is_mri;
   logic              auto_hit;

   ea_field_split #(
      .WORD_W      (WORD_W),
      .OFS_W       (OFS_W),
      .MRI_LIMIT   (MRI_LIMIT),
      .CUR_PAGE_EN (CUR_PAGE_EN)
   ) u_split (
      .instr       (instr_i),
      .pc          (pc_i),
      .direct_addr (direct_addr),
      .indirect    (indirect),
      .is_mri      (is_mri)
   );

   ea_autoidx_match #(
      .WORD_W     (WORD_W),
      .AUTO_BASE  (AUTO_BASE),
      .AUTO_COUNT (AUTO_COUNT),
      .AUTO_EN    (AUTO_EN)
   ) u_match (
      .addr (direct_addr),
      .hit  (auto_hit)
   );

   ea_seq_fsm #(
      .WORD_W (WORD_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start_i),
      .is_mri      (is_mri),
      .indirect    (indirect),
      .auto_hit    (auto_hit),
      .direct_addr (direct_addr),
      .mem_addr    (mem_addr_o),
      .mem_wdata   (mem_wdata_o),
      .mem_we      (mem_we_o),
      .mem_valid   (mem_valid_o),
      .mem_ready   (mem_ready_i),
      .mem_rdata   (mem_rdata_i),
      .ea          (ea_o),
      .done        (done_o),
      .bypass      (bypass_o),
      .busy        (busy_o)
   );

   // R5
   write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (int'(mem_addr_o) >= AUTO_BASE && int'(mem_addr_o) < WIN_HI));

   // R8
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !done_o && mem_valid_o && !mem_ready_i) |=>
         $stable(mem_addr_o));
endmodule

// File: tb/paged_ea_gen_test.sv
`timescale 1ns/1ps
module paged_ea_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [11:0] instr_i = '0;
   logic [11:0] pc_i = '0;
   logic [11:0] mem_addr_o, mem_wdata_o, mem_rdata_i, ea_o;
   logic        mem_we_o, mem_valid_o, mem_ready_i, done_o, bypass_o, busy_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   paged_ea_gen uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i), .pc_i(pc_i),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
      .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
      .ea_o(ea_o), .done_o(done_o), .bypass_o(bypass_o), .busy_o(busy_o)
   );

   // behavioural memory, 512 words (addresses used stay below 0x200)
   logic [11:0] mem [0:511];
   logic        bd_we = 1'b0;
   logic [8:0]  bd_addr = '0;
   logic [11:0] bd_data = '0;
   logic [3:0]  stall_cfg = '0;
   logic [3:0]  stall_ctr = '0;
   int rd_tot = 0, wr_tot = 0, val_tot = 0, done_tot = 0;

   assign mem_ready_i = mem_valid_o && (stall_ctr >= stall_cfg);
   assign mem_rdata_i = mem[mem_addr_o[8:0]];

   always @(posedge clk) begin
      if (bd_we) mem[bd_addr] <= bd_data;
      else if (mem_valid_o && mem_ready_i && mem_we_o) mem[mem_addr_o[8:0]] <= mem_wdata_o;
      if (!mem_valid_o || mem_ready_i) stall_ctr <= '0;
      else stall_ctr <= stall_ctr + 4'd1;
      if (mem_valid_o) val_tot <= val_tot + 1;
      if (mem_valid_o && mem_ready_i && !mem_we_o) rd_tot <= rd_tot + 1;
      if (mem_valid_o && mem_ready_i && mem_we_o) wr_tot <= wr_tot + 1;
      if (done_o) done_tot <= done_tot + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic poke(input logic [8:0] a, input logic [11:0] d);
      @(negedge clk);
      bd_we = 1'b1; bd_addr = a; bd_data = d;
      @(negedge clk);
      bd_we = 1'b0;
   endtask

   function automatic logic [11:0] mk(input int op, input bit ind, input bit ps, input int ofs);
      return {op[2:0], ind, ps, ofs[6:0]};
   endfunction

   // launch one operation and check its result, latency and memory traffic
   task automatic run_op(input string req, input logic [11:0] ins, input logic [11:0] pc,
                         input int stall, input int exp_ea, input int exp_lat,
                         input int exp_rd, input int exp_wr, input int exp_byp);
      int lat, rd0, wr0, val0;
      @(negedge clk);
      stall_cfg = 4'(stall);
      instr_i = ins; pc_i = pc; start_i = 1'b1;
      rd0 = rd_tot; wr0 = wr_tot; val0 = val_tot;
      lat = 0;
      while (lat < 40) begin
         @(negedge clk);
         start_i = 1'b0;
         lat++;
         if (done_o) break;
      end
      check({req, " ea"}, int'(ea_o), exp_ea);
      check({req, " latency"}, lat, exp_lat);
      check({req, " bypass"}, int'(bypass_o), exp_byp);
      @(negedge clk);
      check({req, " done one cycle (R7)"}, int'(done_o), 0);
      check({req, " reads"}, rd_tot - rd0, exp_rd);
      check({req, " writes"}, wr_tot - wr0, exp_wr);
      if (exp_rd + exp_wr == 0) check({req, " no mem cycles"}, val_tot - val0, 0);
      check({req, " idle after"}, int'(busy_o), 0);
   endtask

   task automatic t_reset();
      check("R9 done", int'(done_o), 0);
      check("R9 busy", int'(busy_o), 0);
      check("R9 valid", int'(mem_valid_o), 0);
      check("R9 we", int'(mem_we_o), 0);
   endtask

   task automatic t_direct();
      run_op("R1 zero page", mk(1, 0, 0, 'h25), 12'h5A3, 0, 'h025, 1, 0, 0, 0);
      run_op("R2 current page", mk(2, 0, 1, 'h11), 12'hB8F, 0, 'hB91, 1, 0, 0, 0);
      run_op("R2 page edge", mk(5, 0, 1, 'h7F), 12'hF80, 0, 'hFFF, 1, 0, 0, 0);
   endtask

   task automatic t_indirect();
      poke(9'h040, 12'h1C5);
      poke(9'h1C5, 12'h123);
      run_op("R3 indirect", mk(3, 1, 0, 'h40), 12'h700, 0, 'h1C5, 2, 1, 0, 0);
      check("R3 pointer unchanged", int'(mem[9'h040]), 'h1C5);
      poke(9'h10A, 12'h456);
      run_op("R10 R3 cur page stall", mk(4, 1, 1, 'h0A), 12'h105, 2, 'h456, 4, 1, 0, 0);
      check("R5 page-two pointer unchanged", int'(mem[9'h10A]), 'h456);
   endtask

   task automatic t_auto();
      poke(9'h008, 12'h1FF);
      run_op("R4 auto low", mk(0, 1, 0, 'h08), 12'h200, 0, 'h200, 3, 1, 1, 0);
      check("R4 written back", int'(mem[9'h008]), 'h200);
      poke(9'h00F, 12'hFFF);
      run_op("R4 auto wrap stall", mk(1, 1, 0, 'h0F), 12'h200, 1, 'h000, 5, 1, 1, 0);
      check("R4 wrapped value", int'(mem[9'h00F]), 'h000);
      poke(9'h010, 12'h050);
      run_op("R5 above window", mk(1, 1, 0, 'h10), 12'h000, 0, 'h050, 2, 1, 0, 0);
      check("R5 0x010 unchanged", int'(mem[9'h010]), 'h050);
      poke(9'h007, 12'h0AA);
      run_op("R5 below window", mk(2, 1, 0, 'h07), 12'h000, 0, 'h0AA, 2, 1, 0, 0);
      check("R5 0x007 unchanged", int'(mem[9'h007]), 'h0AA);
   endtask

   task automatic t_bypass();
      run_op("R6 opcode 6", mk(6, 1, 0, 'h08), 12'h300, 0, 'h008, 1, 0, 0, 1);
      run_op("R6 opcode 7", mk(7, 0, 1, 'h12), 12'h300, 0, 'h312, 1, 0, 0, 1);
   endtask

   task automatic t_busy_start();
      int lat, d0;
      poke(9'h050, 12'h0AB);
      @(negedge clk);
      stall_cfg = 4'd3;
      instr_i = mk(5, 1, 0, 'h50); pc_i = 12'h000; start_i = 1'b1;
      d0 = done_tot;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      instr_i = mk(7, 0, 0, 'h01); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      check("R8 ea of first op", int'(ea_o), 'h0AB);
      check("R8 no bypass", int'(bypass_o), 0);
      repeat (3) @(negedge clk);
      check("R8 single done", done_tot - d0, 1);
      check("R8 idle", int'(busy_o), 0);
      stall_cfg = 4'd0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_indirect();
      t_auto();
      t_bypass();
      t_busy_start();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule